// File: doc/BRIEF.md
# Dual-lane ADC serial output emulator

This block stands in for the digital side of a two-channel, simultaneous-sampling ADC so that a host serial controller can be exercised against it. Two parallel conversion words and a resolution select (14-bit or 12-bit) are presented on its inputs. The host drives a chip-select and a serial clock. The block samples both of these with its own system clock and acts on their edges.

When chip-select goes low, both serial data lanes are enabled and start at zero. Falling edges of the serial clock then launch bits. The first falling edge carries a leading zero, the data follows MSB first, and any surplus edges carry zeros. The two lanes shift in lockstep. The block counts rising edges of the serial clock to decide when a frame is complete. If chip-select rises before that count is reached, the frame is reported as aborted. Both outcomes emit a one-cycle pulse telling the environment that acquisition of the next sample begins.

The system clock must run at least four times faster than the serial clock. The block reacts to a pin edge within three system-clock cycles.

Top module: `dual_lane_adc_sdo`

## Requirements
- R1: After reset, sdo_oe, sdo_a, sdo_b, frame_done, frame_abort and acquire are all 0.
- R2: A falling edge on cs_n sets sdo_oe to 1 and drives 0 on both lanes, before any sclk edge arrives.
- R3: The lanes carry the data as follows. Falling sclk edge 1 drives 0. Falling edge k (k ≥ 2) drives bit N+1-k of the lane's word, so the MSB comes on edge 2 and D0 on edge N+1. With res14=1, N is 14 and the full word is used. With res14=0, N is 12 and word bits [11:0] are used. sdo_a is taken from word_a and sdo_b from word_b, in the same slot.
- R4: Every falling sclk edge after edge N+1 drives 0 on both lanes.
- R5: A rising edge on cs_n sets sdo_oe to 0, and both lanes then hold 0.
- R6: frame_done pulses for exactly one cycle when the count of rising sclk edges in the frame reaches N+2 (16 or 14). Further rising edges in the same frame give no further pulse.
- R7: If cs_n rises after fewer than N+2 rising sclk edges, frame_abort pulses for one cycle and frame_done does not pulse in that frame. This includes the case of zero edges.
- R8: acquire pulses exactly once per frame, in the same cycle as frame_done or frame_abort.
- R9: The words and res14 are captured on the cs_n falling edge. Later changes to them during the frame do not affect the bits shifted out.
- R10: sclk toggling while cs_n is high leaves sdo_oe, both lanes and all pulse outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the sclk rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| res14 | input | 1 | 1 selects 14-bit words, 0 selects 12-bit |
| word_a | input | 14 | Conversion result for lane A |
| word_b | input | 14 | Conversion result for lane B |
| cs_n | input | 1 | Frame select from host, active low |
| sclk | input | 1 | Serial clock from host |
| sdo_a | output | 1 | Serial data, lane A |
| sdo_b | output | 1 | Serial data, lane B |
| sdo_oe | output | 1 | Output enable for both lanes (0 = high impedance) |
| acquire | output | 1 | Pulse: acquisition of the next sample starts |
| frame_done | output | 1 | Pulse: frame reached its full rising-edge count |
| frame_abort | output | 1 | Pulse: frame ended early by cs_n |

## Verification
The bench sweeps both resolutions across several data patterns. It runs frames with exactly the required clock count and with surplus clocks.

A design that skipped the leading zero slot, or mis-sized the 12-bit window, would show every bit one position off or leak upper word bits into the data. One that kept shifting real data past D0 would fail the padding checks.

Early ends are tried at every rising-edge count from zero up to one short of completion. An off-by-one in the completion count would report a done frame as aborted, or the reverse.

Inputs are changed right after the frame opens, so a design that reads the word live rather than capturing it would corrupt the stream. Sclk toggling between frames exposes a design that acts on clock edges while deselected.

// File: rtl/dual_lane_adc_sdo.sv
module dual_lane_adc_sdo #(
  parameter int DW = 14,
  parameter int SW = 12,
  parameter int CW = $clog2(DW + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res14,
  input  logic [DW-1:0] word_a,
  input  logic [DW-1:0] word_b,
  input  logic          cs_n,
  input  logic          sclk,
  output logic          sdo_a,
  output logic          sdo_b,
  output logic          sdo_oe,
  output logic          acquire,
  output logic          frame_done,
  output logic          frame_abort
);
  localparam logic [CW-1:0] LONG_N  = CW'(DW + 2);
  localparam logic [CW-1:0] SHORT_N = CW'(SW + 2);

  logic [2:0]    cs_sy, sk_sy;
  logic [DW-1:0] sh_a, sh_b;
  logic [CW-1:0] rise_cnt;
  logic          res_q, lead;

  wire cs_fall = cs_sy[2] & ~cs_sy[1];
  wire cs_rise = ~cs_sy[2] & cs_sy[1];
  wire sk_fall = sk_sy[2] & ~sk_sy[1];
  wire sk_rise = ~sk_sy[2] & sk_sy[1];
  wire [CW-1:0] need = res_q ? LONG_N : SHORT_N;

  assign acquire = frame_done | frame_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 3'b111;
      sk_sy <= 3'b111;
    end else begin
      cs_sy <= {cs_sy[1:0], cs_n};
      sk_sy <= {sk_sy[1:0], sclk};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_oe      <= 1'b0;
      sdo_a       <= 1'b0;
      sdo_b       <= 1'b0;
      sh_a        <= '0;
      sh_b        <= '0;
      res_q       <= 1'b0;
      lead        <= 1'b0;
      rise_cnt    <= '0;
      frame_done  <= 1'b0;
      frame_abort <= 1'b0;
    end else begin
      frame_done  <= 1'b0;
      frame_abort <= 1'b0;
      if (cs_fall) begin
        sdo_oe   <= 1'b1;
        sdo_a    <= 1'b0;
        sdo_b    <= 1'b0;
        sh_a     <= res14 ? word_a : {word_a[SW-1:0], {(DW-SW){1'b0}}};
        sh_b     <= res14 ? word_b : {word_b[SW-1:0], {(DW-SW){1'b0}}};
        res_q    <= res14;
        lead     <= 1'b1;
        rise_cnt <= '0;
      end else if (cs_rise) begin
        sdo_oe <= 1'b0;
        sdo_a  <= 1'b0;
        sdo_b  <= 1'b0;
        if (sdo_oe && rise_cnt < need) frame_abort <= 1'b1;
      end else if (sdo_oe) begin
        if (sk_fall) begin
          if (lead) begin
            lead  <= 1'b0;
            sdo_a <= 1'b0;
            sdo_b <= 1'b0;
          end else begin
            sdo_a <= sh_a[DW-1];
            sdo_b <= sh_b[DW-1];
            sh_a  <= sh_a << 1;
            sh_b  <= sh_b << 1;
          end
        end
        if (sk_rise && rise_cnt < need) begin
          rise_cnt <= rise_cnt + CW'(1);
          if (rise_cnt + CW'(1) == need) frame_done <= 1'b1;
        end
      end
    end
  end

  // R5
  idle_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> (!sdo_a && !sdo_b));
  // R2
  open_drives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_oe && !sdo_a && !sdo_b));
  // R5
  close_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_oe);
  // R7
  abort_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> $past(cs_rise));
  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_abort));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= LONG_N);
endmodule

// File: tb/dual_lane_adc_sdo_tb.sv
module dual_lane_adc_sdo_tb_top;
  logic clk = 0, rst_n = 0, res14 = 0, cs_n = 1, sclk = 1;
  logic [13:0] word_a = '0, word_b = '0;
  logic sdo_a, sdo_b, sdo_oe, acquire, frame_done, frame_abort;
  int n_chk = 0, n_bad = 0;
  int n_done = 0, n_abort = 0, n_acq = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_lane_adc_sdo dut_i (
    .clk(clk), .rst_n(rst_n), .res14(res14), .word_a(word_a), .word_b(word_b),
    .cs_n(cs_n), .sclk(sclk), .sdo_a(sdo_a), .sdo_b(sdo_b), .sdo_oe(sdo_oe),
    .acquire(acquire), .frame_done(frame_done), .frame_abort(frame_abort));

  always @(posedge clk) begin
    if (frame_done)  n_done  <= n_done + 1;
    if (frame_abort) n_abort <= n_abort + 1;
    if (acquire)     n_acq   <= n_acq + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic frame(input bit res, input logic [13:0] a, input logic [13:0] b, input int ncyc);
    int nb = res ? 14 : 12;
    int d0, a0, q0;
    int eb_a, eb_b;
    res14 = res; word_a = a; word_b = b;
    tick(2);
    d0 = n_done; a0 = n_abort; q0 = n_acq;
    cs_n = 0;
    tick(6);
    chk(sdo_oe == 1, "R2 oe", int'(sdo_oe), 1);
    chk({sdo_a, sdo_b} == 2'b00, "R2 lanes", int'({sdo_a, sdo_b}), 0);
    word_a = ~a; word_b = ~b; res14 = ~res;
    for (int k = 1; k <= ncyc; k++) begin
      sclk = 0;
      tick(6);
      if (k >= 2 && k - 2 < nb) begin
        eb_a = int'(a[nb + 1 - k]);
        eb_b = int'(b[nb + 1 - k]);
        chk(sdo_a == eb_a[0] && sdo_b == eb_b[0], "R3/R9 bit",
            int'({sdo_a, sdo_b}), eb_a * 2 + eb_b);
      end else begin
        chk({sdo_a, sdo_b} == 2'b00, k == 1 ? "R3 lead" : "R4 pad",
            int'({sdo_a, sdo_b}), 0);
      end
      sclk = 1;
      tick(6);
    end
    cs_n = 1;
    tick(6);
    chk(sdo_oe == 0 && {sdo_a, sdo_b} == 2'b00, "R5 close", int'({sdo_oe, sdo_a, sdo_b}), 0);
    chk(n_done - d0 == (ncyc >= nb + 2 ? 1 : 0), "R6 done", n_done - d0, ncyc >= nb + 2 ? 1 : 0);
    chk(n_abort - a0 == (ncyc < nb + 2 ? 1 : 0), "R7 abort", n_abort - a0, ncyc < nb + 2 ? 1 : 0);
    chk(n_acq - q0 == 1, "R8 acquire", n_acq - q0, 1);
  endtask

  initial begin
    logic [13:0] pats [6];
    int d0, a0;
    pats[0] = 14'h0000; pats[1] = 14'h3FFF; pats[2] = 14'h2AAA;
    pats[3] = 14'h1555; pats[4] = 14'h2001; pats[5] = 14'h3A5C;
    tick(3);
    chk(sdo_oe == 0 && {sdo_a, sdo_b} == 2'b00, "R1 lanes", int'({sdo_oe, sdo_a, sdo_b}), 0);
    chk({frame_done, frame_abort, acquire} == 3'b000, "R1 pulses",
        int'({frame_done, frame_abort, acquire}), 0);
    rst_n = 1;
    tick(4);
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < 6; p++) begin
        frame(r[0], pats[p], pats[5 - p] ^ 14'h0F0F, (r == 1 ? 16 : 14) + (p % 3) * 2);
      end
      for (int c = 0; c < (r == 1 ? 16 : 14); c++)
        frame(r[0], pats[c % 6], ~pats[c % 6], c);
    end
    d0 = n_done; a0 = n_abort;
    for (int i = 0; i < 10; i++) begin
      sclk = ~sclk;
      tick(6);
      chk(sdo_oe == 0 && {sdo_a, sdo_b} == 2'b00, "R10 idle", int'({sdo_oe, sdo_a, sdo_b}), 0);
    end
    chk(n_done == d0 && n_abort == a0, "R10 pulses", n_done + n_abort, d0 + a0);
    frame(1'b1, 14'h3A5C, 14'h05A3, 17);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule